// File: doc/BRIEF.md
# Cache Miss Fill Buffer

This block keeps a small pool of tracking entries for lines that missed in a first-level data cache. Each entry stands for a whole line, not a single access. Load misses and store-commit misses come in through one request port. A request to a line that already owns an entry joins that entry. A request to a new line takes the lowest free entry. The index of the entry that took the request is returned in the same cycle, so the requester knows which completion to wait for.

Each entry sends exactly one request downstream. A load asks for a shared copy. A store asks for ownership, meaning an exclusive and writable copy. When the cache already holds the line shared, a store asks for an ownership upgrade: the response to it carries no data. The response returns the whole line in one beat, tagged with the entry index. The next cycle the block presents the line on the install port. That install pulse, carrying the entry index, is also the completion signal for every requester waiting on that entry. The entry is free again in the following cycle.

Top module: `line_miss_buffer`

## Requirements
- R1: An accepted request to a line with no entry allocates the lowest-numbered free entry, and `reqEntryIdx` shows that index while `reqValid` and `reqReady` are both high.
- R2: A request to a line that already has a busy entry is accepted into that entry. `reqEntryIdx` shows the entry's index, no new entry is allocated, and no second downstream request is made for the line.
- R3: Each allocated entry raises exactly one downstream request. The earliest cycle for it is the one after allocation. When several entries are pending, the lowest index goes first. `dnReqExcl` is 0 for a load-allocated entry and 1 for a store-allocated entry, and `dnReqLineAddr` is the entry's line.
- R4: A store that allocates with `reqHeldShared`=1 requests with `dnReqExcl`=1 and `dnReqNoData`=1. Its install comes out with `instDataValid`=0 and `instExcl`=1.
- R5: A store that joins a shared-request entry whose request has not yet been sent changes that request to exclusive (`dnReqExcl`=1).
- R6: A store to a line whose shared request has already been sent (or is being sent in that cycle) is held off with `reqReady`=0.
- R7: When every entry is busy, a request to a line with no entry sees `reqReady`=0. A request that joins an existing entry is still accepted.
- R8: A response accepted in cycle t for an entry that is waiting produces an install in cycle t+1. The install carries `instEntry`, `instLineAddr` and `instData` from that response and `instExcl` of the entry, with `instDataValid`=1 for a data fill.
- R9: An entry is free from the cycle after its install. In the install cycle itself, a request to the line being installed sees `reqReady`=0.
- R10: After reset every entry is free: `reqReady`=1, `dnReqValid`=0 and `instValid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | A miss request is offered |
| reqReady | output | 1 | The offered request is accepted this cycle |
| reqLineAddr | input | MLB_ADDR_W | Line address of the request |
| reqIsStore | input | 1 | 1 for a store-commit miss, 0 for a load miss |
| reqHeldShared | input | 1 | The cache holds the line shared (store upgrade) |
| reqEntryIdx | output | MLB_IDX_W | Entry index that takes the request |
| dnReqValid | output | 1 | A downstream line request is pending |
| dnReqReady | input | 1 | The next level takes the downstream request |
| dnReqEntry | output | MLB_IDX_W | Entry index tag of the downstream request |
| dnReqLineAddr | output | MLB_ADDR_W | Line address requested |
| dnReqExcl | output | 1 | 1 asks for ownership, 0 asks for a shared copy |
| dnReqNoData | output | 1 | Upgrade only: the response will carry no data |
| rspValid | input | 1 | A downstream response is present |
| rspEntry | input | MLB_IDX_W | Entry index the response belongs to |
| rspData | input | MLB_LINE_W | Whole line data of the response |
| instValid | output | 1 | Install and completion pulse |
| instEntry | output | MLB_IDX_W | Entry index being completed |
| instLineAddr | output | MLB_ADDR_W | Line address being installed |
| instData | output | MLB_LINE_W | Line data to write into the cache |
| instExcl | output | 1 | Install the line as writable (1) or shared (0) |
| instDataValid | output | 1 | 1 when instData must be written, 0 for a state-only upgrade |

## Verification
The bench first runs a single line through joining loads, a store that joins before the request is sent and is promoted, and an upgrade-only store. These tell apart a shared request, an exclusive request and a no-data request, and show whether a join really avoids a second request. It then checks the conflict cases: a store that arrives after a shared request has been sent, and a request to a line in its install cycle. Both must be held off, and the second must be accepted again once the entry frees. A full sweep fills every entry with alternating loads and stores, shows that a new line is refused while a joining request is still taken, and issues the entries in index order. Responses then come back in reverse order with per-entry data, which shows that each install is tied to its response tag and not to its allocation order.

// File: rtl/mlb_pkg.sv
package mlb_pkg;
  parameter int MLB_ENTRIES = 8;
  parameter int MLB_ADDR_W  = 12;
  parameter int MLB_LINE_W  = 64;
  localparam int MLB_IDX_W  = (MLB_ENTRIES > 1) ? $clog2(MLB_ENTRIES) : 1;

  typedef logic [MLB_ENTRIES-1:0] entVec_t;

  typedef enum logic [1:0] {
    EFREE  = 2'd0,
    EISSUE = 2'd1,
    EWAIT  = 2'd2,
    EREADY = 2'd3
  } entState_t;

  // strobes from control to datapath
  typedef struct packed {
    entVec_t allocOh;
    entVec_t promoteOh;
    entVec_t captureOh;
    logic    allocExcl;
    logic    allocNoData;
  } dpStrobe_t;

  function automatic logic [MLB_IDX_W-1:0] lowIdx(input entVec_t v);
    logic [MLB_IDX_W-1:0] r;
    r = '0;
    for (int i = MLB_ENTRIES - 1; i >= 0; i--) begin
      if (v[i]) r = i[MLB_IDX_W-1:0];
    end
    return r;
  endfunction

  function automatic entVec_t lowOh(input entVec_t v);
    return v & (~v + entVec_t'(1));
  endfunction
endpackage

// File: rtl/mlb_data.sv
module mlb_data
  import mlb_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  dpStrobe_t             strb,
  input  logic [MLB_ADDR_W-1:0] reqLineAddr,
  input  logic [MLB_LINE_W-1:0] rspData,
  input  logic [MLB_IDX_W-1:0]  issueIdx,
  input  logic [MLB_IDX_W-1:0]  instIdx,
  output entVec_t               lineMatch,
  output entVec_t               exclVec,
  output entVec_t               noDataVec,
  output logic [MLB_ADDR_W-1:0] issueAddr,
  output logic [MLB_ADDR_W-1:0] instAddr,
  output logic [MLB_LINE_W-1:0] instData
);
  logic [MLB_ADDR_W-1:0] addrArr [MLB_ENTRIES];
  logic [MLB_LINE_W-1:0] dataArr [MLB_ENTRIES];

  for (genvar g = 0; g < MLB_ENTRIES; g++) begin : g_ent
    logic [MLB_ADDR_W-1:0] addrQ;
    logic [MLB_LINE_W-1:0] dataQ;
    logic                  exclQ;
    logic                  noDataQ;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        addrQ   <= '0;
        exclQ   <= 1'b0;
        noDataQ <= 1'b0;
      end else if (strb.allocOh[g]) begin
        addrQ   <= reqLineAddr;
        exclQ   <= strb.allocExcl;
        noDataQ <= strb.allocNoData;
      end else if (strb.promoteOh[g]) begin
        exclQ   <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) dataQ <= '0;
      else if (strb.captureOh[g]) dataQ <= rspData;
    end

    assign addrArr[g]   = addrQ;
    assign dataArr[g]   = dataQ;
    assign exclVec[g]   = exclQ;
    assign noDataVec[g] = noDataQ;
    assign lineMatch[g] = (addrQ == reqLineAddr);
  end

  assign issueAddr = addrArr[issueIdx];
  assign instAddr  = addrArr[instIdx];
  assign instData  = dataArr[instIdx];
endmodule

// File: rtl/mlb_ctrl.sv
module mlb_ctrl
  import mlb_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  input  logic                 reqIsStore,
  input  logic                 reqHeldShared,
  input  entVec_t              lineMatch,
  input  entVec_t              exclVec,
  output logic                 reqReady,
  output logic [MLB_IDX_W-1:0] reqEntryIdx,
  output logic                 dnReqValid,
  input  logic                 dnReqReady,
  output logic [MLB_IDX_W-1:0] issueIdx,
  input  logic                 rspValid,
  input  logic [MLB_IDX_W-1:0] rspEntry,
  output logic                 instValid,
  output logic [MLB_IDX_W-1:0] instIdx,
  output dpStrobe_t            strb
);
  entVec_t busyVec, pendVec, waitVec, readyVec;
  entVec_t hitVec, freeVec, issueOh, instOh, issueNowOh;
  logic    anyHit, anyFree, issueFire, accept;
  logic    hitShared, hitUnissued, hitInstalling, storeBlock;

  for (genvar g = 0; g < MLB_ENTRIES; g++) begin : g_st
    entState_t stQ;

    always_ff @(posedge clk) begin
      if (!rstN) stQ <= EFREE;
      else begin
        case (stQ)
          EFREE:   if (strb.allocOh[g]) stQ <= EISSUE;
          EISSUE:  if (issueFire && issueOh[g]) stQ <= EWAIT;
          EWAIT:   if (strb.captureOh[g]) stQ <= EREADY;
          default: if (instOh[g]) stQ <= EFREE;
        endcase
      end
    end

    assign busyVec[g]  = (stQ != EFREE);
    assign pendVec[g]  = (stQ == EISSUE);
    assign waitVec[g]  = (stQ == EWAIT);
    assign readyVec[g] = (stQ == EREADY);
    assign strb.captureOh[g] = rspValid && (rspEntry == MLB_IDX_W'(g)) && waitVec[g];
  end

  always_comb begin
    hitVec   = lineMatch & busyVec;
    anyHit   = |hitVec;
    freeVec  = ~busyVec;
    anyFree  = |freeVec;

    issueOh    = lowOh(pendVec);
    dnReqValid = |pendVec;
    issueIdx   = lowIdx(pendVec);
    issueFire  = dnReqValid && dnReqReady;
    issueNowOh = issueFire ? issueOh : '0;

    instOh    = lowOh(readyVec);
    instValid = |readyVec;
    instIdx   = lowIdx(readyVec);

    hitShared     = |(hitVec & ~exclVec);
    hitUnissued   = |(hitVec & pendVec & ~issueNowOh);
    hitInstalling = |(hitVec & instOh);
    storeBlock    = reqIsStore && hitShared && !hitUnissued;

    reqReady    = anyHit ? !(hitInstalling || storeBlock) : anyFree;
    reqEntryIdx = anyHit ? lowIdx(hitVec) : lowIdx(freeVec);
    accept      = reqValid && reqReady;

    strb.allocOh     = (accept && !anyHit) ? lowOh(freeVec) : '0;
    strb.promoteOh   = (accept && anyHit && reqIsStore) ? (hitVec & ~exclVec) : '0;
    strb.allocExcl   = reqIsStore;
    strb.allocNoData = reqIsStore && reqHeldShared;
  end
endmodule

// File: rtl/line_miss_buffer.sv
module line_miss_buffer
  import mlb_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  reqValid,
  output logic                  reqReady,
  input  logic [MLB_ADDR_W-1:0] reqLineAddr,
  input  logic                  reqIsStore,
  input  logic                  reqHeldShared,
  output logic [MLB_IDX_W-1:0]  reqEntryIdx,
  output logic                  dnReqValid,
  input  logic                  dnReqReady,
  output logic [MLB_IDX_W-1:0]  dnReqEntry,
  output logic [MLB_ADDR_W-1:0] dnReqLineAddr,
  output logic                  dnReqExcl,
  output logic                  dnReqNoData,
  input  logic                  rspValid,
  input  logic [MLB_IDX_W-1:0]  rspEntry,
  input  logic [MLB_LINE_W-1:0] rspData,
  output logic                  instValid,
  output logic [MLB_IDX_W-1:0]  instEntry,
  output logic [MLB_ADDR_W-1:0] instLineAddr,
  output logic [MLB_LINE_W-1:0] instData,
  output logic                  instExcl,
  output logic                  instDataValid
);
  dpStrobe_t            strb;
  entVec_t              lineMatch, exclVec, noDataVec;
  logic [MLB_IDX_W-1:0] issueIdx, instIdx;

  mlb_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqIsStore(reqIsStore), .reqHeldShared(reqHeldShared),
    .lineMatch(lineMatch), .exclVec(exclVec),
    .reqReady(reqReady), .reqEntryIdx(reqEntryIdx),
    .dnReqValid(dnReqValid), .dnReqReady(dnReqReady), .issueIdx(issueIdx),
    .rspValid(rspValid), .rspEntry(rspEntry),
    .instValid(instValid), .instIdx(instIdx),
    .strb(strb)
  );

  mlb_data u_data (
    .clk(clk), .rstN(rstN), .strb(strb),
    .reqLineAddr(reqLineAddr), .rspData(rspData),
    .issueIdx(issueIdx), .instIdx(instIdx),
    .lineMatch(lineMatch), .exclVec(exclVec), .noDataVec(noDataVec),
    .issueAddr(dnReqLineAddr), .instAddr(instLineAddr), .instData(instData)
  );

  assign dnReqEntry    = issueIdx;
  assign dnReqExcl     = exclVec[issueIdx];
  assign dnReqNoData   = noDataVec[issueIdx];
  assign instEntry     = instIdx;
  assign instExcl      = exclVec[instIdx];
  assign instDataValid = !noDataVec[instIdx];
endmodule

// File: rtl/mlb_check.sv
module mlb_check
  import mlb_pkg::*;
(
  input logic                  clk,
  input logic                  rstN,
  input logic                  reqValid,
  input logic                  reqReady,
  input logic [MLB_ADDR_W-1:0] reqLineAddr,
  input logic                  dnReqValid,
  input logic                  dnReqReady,
  input logic [MLB_IDX_W-1:0]  dnReqEntry,
  input logic                  dnReqExcl,
  input logic                  dnReqNoData,
  input logic                  rspValid,
  input logic [MLB_IDX_W-1:0]  rspEntry,
  input logic                  instValid,
  input logic [MLB_IDX_W-1:0]  instEntry,
  input logic [MLB_ADDR_W-1:0] instLineAddr
);
  a_r8_install_after_rsp: assert property (@(posedge clk) disable iff (!rstN)
    instValid |-> ($past(rspValid) && ($past(rspEntry) == instEntry)));

  a_r9_hold_installing_line: assert property (@(posedge clk) disable iff (!rstN)
    (instValid && reqValid && (reqLineAddr == instLineAddr)) |-> !reqReady);

  a_r4_upgrade_is_excl: assert property (@(posedge clk) disable iff (!rstN)
    (dnReqValid && dnReqNoData) |-> dnReqExcl);

  a_r3_single_issue: assert property (@(posedge clk) disable iff (!rstN)
    (dnReqValid && dnReqReady) |=> !(dnReqValid && (dnReqEntry == $past(dnReqEntry))));

  a_r10_idle_after_reset: assert property (@(posedge clk)
    $rose(rstN) |-> (!dnReqValid && !instValid));
endmodule

bind line_miss_buffer mlb_check u_check (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .reqLineAddr(reqLineAddr), .dnReqValid(dnReqValid), .dnReqReady(dnReqReady),
  .dnReqEntry(dnReqEntry), .dnReqExcl(dnReqExcl), .dnReqNoData(dnReqNoData),
  .rspValid(rspValid), .rspEntry(rspEntry), .instValid(instValid),
  .instEntry(instEntry), .instLineAddr(instLineAddr)
);

// File: tb/line_miss_buffer_test.sv
module line_miss_buffer_test;
  import mlb_pkg::*;

  logic                  clk = 1'b0;
  logic                  rstN = 1'b0;
  logic                  reqValid = 1'b0, reqReady, reqIsStore = 1'b0, reqHeldShared = 1'b0;
  logic [MLB_ADDR_W-1:0] reqLineAddr = '0;
  logic [MLB_IDX_W-1:0]  reqEntryIdx;
  logic                  dnReqValid, dnReqReady = 1'b0, dnReqExcl, dnReqNoData;
  logic [MLB_IDX_W-1:0]  dnReqEntry;
  logic [MLB_ADDR_W-1:0] dnReqLineAddr;
  logic                  rspValid = 1'b0;
  logic [MLB_IDX_W-1:0]  rspEntry = '0;
  logic [MLB_LINE_W-1:0] rspData = '0;
  logic                  instValid, instExcl, instDataValid;
  logic [MLB_IDX_W-1:0]  instEntry;
  logic [MLB_ADDR_W-1:0] instLineAddr;
  logic [MLB_LINE_W-1:0] instData;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  line_miss_buffer uut (.*);

  task automatic cyc;
    @(posedge clk);
    #2;
  endtask

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic setReq(input logic v, input int addr, input logic st, input logic hs);
    reqValid      = v;
    reqLineAddr   = MLB_ADDR_W'(addr);
    reqIsStore    = st;
    reqHeldShared = hs;
    #1;
  endtask

  function automatic logic [MLB_LINE_W-1:0] pat(input int i);
    return MLB_LINE_W'(64'h0123_4567_89AB_CDEF ^ (64'(i) * 64'h1111));
  endfunction

  task automatic summary;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(8 * 20000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      summary();
    end
  end

  initial begin
    repeat (3) cyc();
    rstN = 1'b1;
    #1;
    chk("R10 reqReady", 64'(reqReady), 1);
    chk("R10 dnReqValid", 64'(dnReqValid), 0);
    chk("R10 instValid", 64'(instValid), 0);

    // single line: load, joining load, promoting store
    setReq(1, 'h010, 0, 0);
    chk("R1 ready", 64'(reqReady), 1);
    chk("R1 idx", 64'(reqEntryIdx), 0);
    cyc();
    setReq(1, 'h010, 0, 0);
    chk("R2 join ready", 64'(reqReady), 1);
    chk("R2 join idx", 64'(reqEntryIdx), 0);
    chk("R3 dnValid", 64'(dnReqValid), 1);
    chk("R3 dnAddr", 64'(dnReqLineAddr), 'h010);
    chk("R3 load shared", 64'(dnReqExcl), 0);
    cyc();
    setReq(1, 'h010, 1, 0);
    chk("R5 store join ready", 64'(reqReady), 1);
    chk("R5 store join idx", 64'(reqEntryIdx), 0);
    cyc();
    setReq(1, 'h020, 1, 1);
    chk("R1 second idx", 64'(reqEntryIdx), 1);
    chk("R5 promoted excl", 64'(dnReqExcl), 1);
    cyc();
    setReq(0, 0, 0, 0);
    dnReqReady = 1'b1;
    #1;
    chk("R3 order first", 64'(dnReqEntry), 0);
    cyc();
    chk("R4 upgrade entry", 64'(dnReqEntry), 1);
    chk("R4 upgrade addr", 64'(dnReqLineAddr), 'h020);
    chk("R4 upgrade excl", 64'(dnReqExcl), 1);
    chk("R4 upgrade nodata", 64'(dnReqNoData), 1);
    cyc();
    dnReqReady = 1'b0;
    #1;
    chk("R2 no second request", 64'(dnReqValid), 0);

    // conflict: store after shared request went out
    setReq(1, 'h040, 0, 0);
    chk("R1 third idx", 64'(reqEntryIdx), 2);
    cyc();
    setReq(0, 0, 0, 0);
    dnReqReady = 1'b1;
    cyc();
    dnReqReady = 1'b0;
    setReq(1, 'h040, 1, 0);
    chk("R6 store held off", 64'(reqReady), 0);
    setReq(1, 'h040, 0, 0);
    chk("R2 load join issued", 64'(reqReady), 1);
    chk("R2 load join idx", 64'(reqEntryIdx), 2);
    setReq(0, 0, 0, 0);

    // responses and installs
    rspValid = 1'b1; rspEntry = 2; rspData = pat(2);
    cyc();
    rspValid = 1'b1; rspEntry = 0; rspData = pat(0);
    #1;
    chk("R8 inst valid", 64'(instValid), 1);
    chk("R8 inst entry", 64'(instEntry), 2);
    chk("R8 inst addr", 64'(instLineAddr), 'h040);
    chk("R8 inst data", 64'(instData), 64'(pat(2)));
    chk("R8 inst dataValid", 64'(instDataValid), 1);
    chk("R8 inst shared", 64'(instExcl), 0);
    setReq(1, 'h040, 0, 0);
    chk("R9 installing line held", 64'(reqReady), 0);
    setReq(0, 0, 0, 0);
    cyc();
    rspValid = 1'b1; rspEntry = 1; rspData = '1;
    #1;
    chk("R9 inst next entry", 64'(instEntry), 0);
    chk("R8 inst promoted excl", 64'(instExcl), 1);
    chk("R8 inst data0", 64'(instData), 64'(pat(0)));
    setReq(1, 'h040, 0, 0);
    chk("R9 freed ready", 64'(reqReady), 1);
    chk("R9 freed idx", 64'(reqEntryIdx), 2);
    cyc();
    setReq(0, 0, 0, 0);
    rspValid = 1'b0;
    #1;
    chk("R4 inst entry", 64'(instEntry), 1);
    chk("R4 inst no data", 64'(instDataValid), 0);
    chk("R4 inst excl", 64'(instExcl), 1);
    dnReqReady = 1'b1;
    cyc();
    dnReqReady = 1'b0;
    rspValid = 1'b1; rspEntry = 2; rspData = '0;
    cyc();
    rspValid = 1'b0;
    cyc();
    cyc();

    // sweep: fill every entry
    for (int i = 0; i < MLB_ENTRIES; i++) begin
      setReq(1, 'h100 + i * 3, 1'(i % 2), 0);
      chk("R1 sweep ready", 64'(reqReady), 1);
      chk("R1 sweep idx", 64'(reqEntryIdx), 64'(i));
      cyc();
    end
    setReq(1, 'h7FF, 0, 0);
    chk("R7 full new line", 64'(reqReady), 0);
    setReq(1, 'h100 + 5 * 3, 0, 0);
    chk("R7 full join ready", 64'(reqReady), 1);
    chk("R7 full join idx", 64'(reqEntryIdx), 5);
    setReq(0, 0, 0, 0);
    dnReqReady = 1'b1;
    #1;
    for (int i = 0; i < MLB_ENTRIES; i++) begin
      chk("R3 sweep entry", 64'(dnReqEntry), 64'(i));
      chk("R3 sweep addr", 64'(dnReqLineAddr), 64'('h100 + i * 3));
      chk("R3 sweep excl", 64'(dnReqExcl), 64'(i % 2));
      cyc();
    end
    dnReqReady = 1'b0;
    #1;
    chk("R3 sweep drained", 64'(dnReqValid), 0);
    for (int k = 0; k < MLB_ENTRIES; k++) begin
      rspValid = 1'b1;
      rspEntry = MLB_IDX_W'(MLB_ENTRIES - 1 - k);
      rspData  = pat(MLB_ENTRIES - 1 - k);
      cyc();
      chk("R8 sweep entry", 64'(instEntry), 64'(MLB_ENTRIES - 1 - k));
      chk("R8 sweep data", 64'(instData), 64'(pat(MLB_ENTRIES - 1 - k)));
      chk("R8 sweep addr", 64'(instLineAddr), 64'('h100 + (MLB_ENTRIES - 1 - k) * 3));
    end
    rspValid = 1'b0;
    cyc();
    chk("R9 all free inst", 64'(instValid), 0);
    setReq(1, 'h7FF, 0, 0);
    chk("R9 all free ready", 64'(reqReady), 1);
    chk("R9 all free idx", 64'(reqEntryIdx), 0);
    setReq(0, 0, 0, 0);

    finished = 1'b1;
    summary();
  end
endmodule